// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences an analog-to-digital conversion by binary search. A start request in idle empties the trial register and sets its most significant bit. The register value is driven to an external DAC, and after a fixed number of clock cycles for the DAC to settle, the block samples an external comparator that reports whether the DAC output is above the held analog input. A high comparator clears the trial bit and a low one keeps it. The next lower bit is then set, and the search goes on down to the least significant bit.

When the last bit is decided, the result is loaded into the output code register and a one-cycle end-of-conversion pulse is raised for use as an interrupt. A hold output tells the external sample-and-hold to freeze its input for the whole conversion. The DAC, the comparator and the sample-and-hold are outside this block. A conversion takes WIDTH times SETTLE_CYCLES clock cycles, so every trial has a full settling window.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, dac_code_o, code_o, eoc_o and hold_o are all zero.
- R2: A start_i seen at a clock edge while idle makes dac_code_o equal to a value with only bit WIDTH-1 set from the next cycle on. All earlier trial bits are cleared.
- R3: Each trial value stays on dac_code_o for exactly SETTLE_CYCLES cycles. cmp_high_i is sampled at the edge that ends this window.
- R4: When cmp_high_i is 1 at the sample edge, the bit under trial is cleared. When it is 0, the bit stays at 1. All higher bits keep their decided values.
- R5: Bits are decided in order from bit WIDTH-1 down to bit 0. After each decision except the last, the next lower bit is set to 1 on dac_code_o.
- R6: The edge that decides bit 0 also loads the result into code_o and raises eoc_o for exactly one cycle. eoc_o is seen WIDTH*SETTLE_CYCLES+1 falling edges after the falling edge where start_i is raised.
- R7: code_o changes only in the cycle in which eoc_o is high.
- R8: hold_o is high from the cycle after the accepted start through the last trial cycle. It is low while eoc_o is high.
- R9: start_i has no effect while hold_o is high. The running conversion keeps its bit sequence and its end time.
- R10: With WIDTH=4 and a comparator that reports dac_code_o > 10 (1 V per code), the final code is 4'b1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_high_i | input | 1 | Comparator: 1 when the DAC output is above the analog input |
| dac_code_o | output | WIDTH | Trial register driven to the DAC |
| hold_o | output | 1 | Freeze request to the sample-and-hold |
| code_o | output | WIDTH | Last completed conversion result |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The comparator is modelled as the integer compare dac_code_o > vin. The input vin is set to zero, full scale, the values just above and just below mid-scale, and the alternating patterns 85 and 170.

Zero and full scale push every trial to the same outcome, clear-all or keep-all. The mid-scale pair differ only in the MSB decision and in the outcome of all the lower bits. The alternating patterns expose any mix-up in bit order or in which bit gets cleared.

A start pulse during a conversion checks that the sequence and the timing are not disturbed. A second 4-bit instance with input 10 checks the hand-worked search result.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_TRIAL = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 3,
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == CW'(SETTLE_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/sar_bit_walker.sv
module sar_bit_walker #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  output logic [WIDTH-1:0] ptr_o,
  output logic             last_o
);
  logic [WIDTH-1:0] ptr_q;

  assign ptr_o  = ptr_q;
  assign last_o = ptr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (load_i)  ptr_q <= {1'b1, {(WIDTH-1){1'b0}}};
    else if (shift_i) ptr_q <= ptr_q >> 1;
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH         = 8,
  parameter int unsigned SETTLE_CYCLES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_high_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             hold_o,
  output logic [WIDTH-1:0] code_o,
  output logic             eoc_o
);
  sar_state_e       state_q, state_d;
  logic [WIDTH-1:0] sar_q, sar_d, kept, ptr;
  logic [WIDTH-1:0] code_q;
  logic             eoc_q;
  logic             start_ok, decide, last, tmr_done, finish;

  assign start_ok = (state_q == ST_IDLE) && start_i;
  assign decide   = (state_q == ST_TRIAL) && tmr_done;
  assign finish   = decide && last;

  sar_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_ok || decide),
    .en_i    (state_q == ST_TRIAL),
    .done_o  (tmr_done)
  );

  sar_bit_walker #(.WIDTH(WIDTH)) u_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .shift_i (decide && !last),
    .ptr_o   (ptr),
    .last_o  (last)
  );

  // trial bit is dropped when the DAC overshoots the input
  assign kept = cmp_high_i ? (sar_q & ~ptr) : sar_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_msb
      assign sar_d[i] = start_ok ? 1'b1 : (decide ? kept[i] : sar_q[i]);
    end else begin : g_low
      assign sar_d[i] = start_ok ? 1'b0
                      : (decide ? (kept[i] | ptr[i+1]) : sar_q[i]);
    end
  end

  always_comb begin
    state_d = state_q;
    if (start_ok)    state_d = ST_TRIAL;
    else if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      code_q  <= '0;
      eoc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sar_q   <= sar_d;
      eoc_q   <= finish;
      if (finish) code_q <= kept;
    end
  end

  assign dac_code_o = sar_q;
  assign hold_o     = (state_q == ST_TRIAL);
  assign code_o     = code_q;
  assign eoc_o      = eoc_q;
endmodule

// File: rtl/sar_ctrl_checker.sv
module sar_ctrl_checker #(
  parameter int unsigned WIDTH         = 8,
  parameter int unsigned SETTLE_CYCLES = 3,
  localparam int unsigned RW = $clog2(SETTLE_CYCLES + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             hold_o,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] code_o,
  input logic             eoc_o
);
  logic [WIDTH-1:0] prev_dac;
  logic             prev_hold;
  logic [RW-1:0]    run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_dac  <= '0;
      prev_hold <= 1'b0;
      run       <= '0;
    end else begin
      prev_dac  <= dac_code_o;
      prev_hold <= hold_o;
      if (!hold_o)                                 run <= '0;
      else if (!prev_hold || dac_code_o != prev_dac) run <= RW'(1);
      else                                         run <= run + RW'(1);
    end
  end

  a_r2_start_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && start_i) |=> (hold_o && dac_code_o == {1'b1, {(WIDTH-1){1'b0}}}));

  a_r3_settle_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && prev_hold && dac_code_o != prev_dac) |-> (run == RW'(SETTLE_CYCLES)));

  a_r3_last_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && prev_hold) |-> (run == RW'(SETTLE_CYCLES)));

  a_r6_eoc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);

  a_r7_code_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |-> $stable(code_o));

  a_r8_hold_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> eoc_o);

  a_r8_no_hold_at_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> !hold_o);

  a_r9_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && start_i && !(dac_code_o[0] && run == RW'(SETTLE_CYCLES)) && !$rose(hold_o))
      |=> hold_o);
endmodule

bind sar_ctrl sar_ctrl_checker #(
  .WIDTH(WIDTH),
  .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .hold_o     (hold_o),
  .dac_code_o (dac_code_o),
  .code_o     (code_o),
  .eoc_o      (eoc_o)
);

// File: tb/tb_sar_ctrl.sv
`timescale 1ns/1ps
module tb_sar_ctrl;
  localparam int W = 8;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_high;
  logic [W-1:0] dac_code, code;
  logic hold, eoc;
  int vin = 0;

  logic start4 = 1'b0;
  logic cmp4, hold4, eoc4;
  logic [3:0] dac4, code4;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign cmp_high = (int'(dac_code) > vin);
  assign cmp4     = (int'(dac4) > 10);

  sar_ctrl #(.WIDTH(W), .SETTLE_CYCLES(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_high_i(cmp_high),
    .dac_code_o(dac_code), .hold_o(hold), .code_o(code), .eoc_o(eoc)
  );

  sar_ctrl #(.WIDTH(4), .SETTLE_CYCLES(2)) dut4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start4), .cmp_high_i(cmp4),
    .dac_code_o(dac4), .hold_o(hold4), .code_o(code4), .eoc_o(eoc4)
  );

  // behavioural reference
  int m_busy, m_sar, m_code, m_eoc, m_bit, m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_sar = 0; m_code = 0; m_eoc = 0; m_bit = 0; m_cnt = 0;
    end else begin
      m_eoc = 0;
      if (m_busy == 0) begin
        if (start) begin
          m_busy = 1; m_sar = 1 << (W-1); m_bit = W-1; m_cnt = 0;
        end
      end else begin
        m_cnt++;
        if (m_cnt == S) begin
          if (m_sar > vin) m_sar = m_sar & ~(1 << m_bit);
          if (m_bit == 0) begin
            m_code = m_sar; m_eoc = 1; m_busy = 0;
          end else begin
            m_bit--; m_sar = m_sar | (1 << m_bit); m_cnt = 0;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(dac_code) == m_sar, "R4 dac_code", int'(dac_code), m_sar);
      check(int'(hold) == m_busy, "R8 hold", int'(hold), m_busy);
      check(int'(code) == m_code, "R7 code", int'(code), m_code);
      check(int'(eoc) == m_eoc, "R6 eoc", int'(eoc), m_eoc);
    end
  end

  task automatic convert(input int v, input bit poke_busy);
    int n = 0;
    int first_change = 0;
    int prev;
    vin = v;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    n = 1;
    start = 1'b0;
    check(dac_code == {1'b1, {(W-1){1'b0}}}, "R2 msb trial", int'(dac_code), 1 << (W-1));
    prev = int'(dac_code);
    while (!eoc && n < 4*W*S) begin
      @(negedge clk);
      n++;
      if (first_change == 0 && int'(dac_code) != prev) first_change = n;
      if (poke_busy && n == 5) start = 1'b1;
      if (poke_busy && n == 7) start = 1'b0;
    end
    start = 1'b0;
    check(first_change == S + 1, "R3 settle", first_change, S + 1);
    check(n == W*S + 1, "R6 timing R9", n, W*S + 1);
    check(int'(code) == v, "R5 final code", int'(code), v);
    @(negedge clk);
    check(!eoc && !hold, "R6 single pulse", int'(eoc), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dac_code == '0 && code == '0 && !eoc && !hold, "R1 reset",
          int'({dac_code, code, eoc, hold}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    convert(0, 1'b0);
    convert(255, 1'b0);
    convert(128, 1'b0);
    convert(127, 1'b0);
    convert(85, 1'b1);
    convert(170, 1'b0);
    convert(10, 1'b1);
    // code must hold between conversions
    vin = 3;
    repeat (5) @(negedge clk);
    check(int'(code) == 10, "R7 hold code", int'(code), 10);

    start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    repeat (4*2 + 2) @(negedge clk);
    check(code4 == 4'b1010, "R10 four bit example", int'(code4), 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule